// File: doc/BRIEF.md
# Forward-Only Operator Interconnect

This block carries results between a row of numbered processing operators. Each operator has one result output and two operand inputs. A result can only travel forward, to an operand input of an operator with a higher number, so no routing pattern can form a loop. A source can reach the operators that follow it, up to a distance of half the operator count. Every possible link has one enable bit.

The routing pattern is held in two registers. Software, or a sequencer, writes the next pattern into a staging register while the live pattern keeps steering data. A one-cycle commit then copies the staging pattern into the live register. When the committed pattern has two or more sources enabled onto the same operand input, the lowest-numbered source is chosen and a clash flag is raised. Every operand input is registered once, so a transfer takes exactly one clock.

The operator count is a parameter meant for values 4 to 12, and the data width is also a parameter. The reach is the operator count divided by two.

Top module: `fwd_op_net`

## Requirements
- R1: After a synchronous active-low reset, every operand input reads data 0 with valid low. The clash flag is low, and the live and staging patterns are all zeros.
- R2: Pattern bit `((s*REACH)+(h-1))*2+p`, with REACH = N_OPS/2 and h in 1..REACH, links source s to port p of operator s+h. A bit whose target operator number is N_OPS or more has no effect. Operand input k on the output buses is port k%2 of operator k/2.
- R3: An operand input presents the data its source drove one clock edge earlier, through exactly one register stage.
- R4: One source can drive several operand inputs in the same cycle when several of its enable bits are set.
- R5: An operand input with no enabled source reads data 0 with valid low.
- R6: A linked operand input's valid equals its source's valid from the previous edge. Operator 0's inputs are never valid.
- R7: If several enabled sources target one operand input, the one with the lowest number is delivered.
- R8: Writing the staging pattern (`cfg_load`) does not change the routing until a commit.
- R9: A commit copies the staging pattern into the live pattern at that edge. Data registered at the following edge uses the new pattern. When load and commit fall in the same cycle, the commit takes the staging value from before that load.
- R10: At each commit, `cfg_conflict` becomes 1 if the committed pattern has any operand input with two or more enabled sources, and 0 otherwise. Between commits it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_load | input | 1 | Write `cfg_word` into the staging pattern |
| cfg_word | input | N_OPS*(N_OPS/2)*2 | Next routing pattern, one bit per link |
| cfg_commit | input | 1 | Copy the staging pattern into the live pattern |
| src_data | input | N_OPS*DATA_W | Operator results, operator s at slice s |
| src_valid | input | N_OPS | Result valid per operator |
| dst_data | output | 2*N_OPS*DATA_W | Operand inputs, slice k = operator k/2, port k%2 |
| dst_valid | output | 2*N_OPS | Operand valid per input |
| cfg_conflict | output | 1 | Clash found in the most recently committed pattern |

## Verification
Some properties are checked on every cycle. The live pattern moves only on a commit and takes the staging value present at that commit. The clash flag holds between commits. Operator 0 never receives a valid operand. The operand input of operator 1 follows source 0's valid with one cycle of delay whenever that link is enabled. Other behaviour can only be shown by the directed scenarios: the exact bit-to-link mapping, fan-out, priority between clashing sources, the effect of out-of-range bits, and the one-cycle gap between a commit and the first data routed by the new pattern.

// File: rtl/fwd_op_net_pkg.sv
// Shared helpers for the forward-only operator interconnect.
// Assumes hop distances start at 1 and two operand ports per operator.
package fwd_op_net_pkg;

    localparam int PORTS_PER_OP = 2;

    // Position of the enable bit linking source src to port prt of operator src+hop.
    function automatic int link_bit(input int src, input int hop, input int prt, input int reach);
        return ((src * reach) + (hop - 1)) * PORTS_PER_OP + prt;
    endfunction

endpackage

// File: rtl/fwd_op_net_cfg_bank.sv
// Two-stage pattern storage: a staging register written by the loader and a
// live register updated by commit. A commit takes the staging value from
// before any load in the same cycle.
module fwd_op_net_cfg_bank #(
    parameter int CFG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] word,
    input  logic             commit,
    output logic [CFG_W-1:0] staged,
    output logic [CFG_W-1:0] live
);

    // Staging and live pattern registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= '0;
            live   <= '0;
        end else begin
            if (load)   staged <= word;
            if (commit) live   <= staged;
        end
    end

endmodule

// File: rtl/fwd_op_net_clash_scan.sv
// Looks at a routing pattern and reports whether any operand input has two
// or more enabled sources. The result is purely combinational.
module fwd_op_net_clash_scan
    import fwd_op_net_pkg::*;
#(
    parameter int N_OPS = 8,
    parameter int REACH = N_OPS / 2,
    parameter int CFG_W = N_OPS * REACH * PORTS_PER_OP
) (
    input  logic [CFG_W-1:0] pattern,
    output logic             clash
);

    localparam int N_IN = N_OPS * PORTS_PER_OP;

    logic [N_IN-1:0] per_input_clash;

    assign per_input_clash[PORTS_PER_OP-1:0] = '0;

    for (genvar d = 1; d < N_OPS; d++) begin : g_dst
        localparam int LO = (d > REACH) ? (d - REACH) : 0;
        for (genvar p = 0; p < PORTS_PER_OP; p++) begin : g_port
            // Flags a second enabled source on this operand input.
            always_comb begin
                logic seen;
                seen = 1'b0;
                per_input_clash[d*PORTS_PER_OP+p] = 1'b0;
                for (int s = LO; s < d; s++) begin
                    if (pattern[link_bit(s, d - s, p, REACH)]) begin
                        if (seen) per_input_clash[d*PORTS_PER_OP+p] = 1'b1;
                        seen = 1'b1;
                    end
                end
            end
        end
    end

    assign clash = |per_input_clash;

endmodule

// File: rtl/fwd_op_net_port_mux.sv
// Selects the source for one operand input (operator DST_OP, port DST_PORT).
// Only sources DST_OP-REACH .. DST_OP-1 are candidates. The lowest-numbered
// enabled source wins. With no enabled source the output is zero and invalid.
module fwd_op_net_port_mux
    import fwd_op_net_pkg::*;
#(
    parameter int N_OPS    = 8,
    parameter int REACH    = N_OPS / 2,
    parameter int DATA_W   = 32,
    parameter int CFG_W    = N_OPS * REACH * PORTS_PER_OP,
    parameter int DST_OP   = 1,
    parameter int DST_PORT = 0
) (
    input  logic [CFG_W-1:0]        pattern,
    input  logic [N_OPS*DATA_W-1:0] src_data,
    input  logic [N_OPS-1:0]        src_valid,
    output logic [DATA_W-1:0]       sel_data,
    output logic                    sel_valid
);

    localparam int LO = (DST_OP > REACH) ? (DST_OP - REACH) : 0;

    // Picks the first enabled candidate, counting up from the lowest source.
    always_comb begin
        logic found;
        found     = 1'b0;
        sel_data  = '0;
        sel_valid = 1'b0;
        for (int s = LO; s < DST_OP; s++) begin
            if (!found && pattern[link_bit(s, DST_OP - s, DST_PORT, REACH)]) begin
                found     = 1'b1;
                sel_data  = src_data[s*DATA_W +: DATA_W];
                sel_valid = src_valid[s];
            end
        end
    end

endmodule

// File: rtl/fwd_op_net.sv
// Forward-only operator interconnect. N_OPS sources feed 2*N_OPS operand
// inputs through per-input selectors driven by the live pattern, followed by
// one register stage. Assumes N_OPS between 4 and 12.
module fwd_op_net
    import fwd_op_net_pkg::*;
#(
    parameter int N_OPS  = 8,
    parameter int DATA_W = 32,
    localparam int REACH = N_OPS / 2,
    localparam int CFG_W = N_OPS * REACH * PORTS_PER_OP,
    localparam int N_IN  = N_OPS * PORTS_PER_OP
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_load,
    input  logic [CFG_W-1:0]         cfg_word,
    input  logic                     cfg_commit,
    input  logic [N_OPS*DATA_W-1:0]  src_data,
    input  logic [N_OPS-1:0]         src_valid,
    output logic [N_IN*DATA_W-1:0]   dst_data,
    output logic [N_IN-1:0]          dst_valid,
    output logic                     cfg_conflict
);

    logic [CFG_W-1:0]       shadow_q;
    logic [CFG_W-1:0]       active_q;
    logic                   staged_clash;
    logic [N_IN*DATA_W-1:0] sel_data;
    logic [N_IN-1:0]        sel_valid;

    fwd_op_net_cfg_bank #(.CFG_W(CFG_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cfg_load),
        .word   (cfg_word),
        .commit (cfg_commit),
        .staged (shadow_q),
        .live   (active_q)
    );

    fwd_op_net_clash_scan #(.N_OPS(N_OPS), .REACH(REACH), .CFG_W(CFG_W)) u_scan (
        .pattern (shadow_q),
        .clash   (staged_clash)
    );

    for (genvar d = 0; d < N_OPS; d++) begin : g_op
        for (genvar p = 0; p < PORTS_PER_OP; p++) begin : g_in
            fwd_op_net_port_mux #(
                .N_OPS(N_OPS), .REACH(REACH), .DATA_W(DATA_W), .CFG_W(CFG_W),
                .DST_OP(d), .DST_PORT(p)
            ) u_mux (
                .pattern   (active_q),
                .src_data  (src_data),
                .src_valid (src_valid),
                .sel_data  (sel_data[(d*PORTS_PER_OP+p)*DATA_W +: DATA_W]),
                .sel_valid (sel_valid[d*PORTS_PER_OP+p])
            );
        end
    end

    // Single output register stage for all operand inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_data  <= '0;
            dst_valid <= '0;
        end else begin
            dst_data  <= sel_data;
            dst_valid <= sel_valid;
        end
    end

    // Clash flag captured from the staging pattern as it is committed.
    always_ff @(posedge clk) begin
        if (!rst_n)          cfg_conflict <= 1'b0;
        else if (cfg_commit) cfg_conflict <= staged_clash;
    end

endmodule

// File: rtl/fwd_op_net_chk.sv
// Temporal checks for the forward-only interconnect, bound into the top.
module fwd_op_net_chk #(
    parameter int N_OPS = 8,
    parameter int CFG_W = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_commit,
    input logic [CFG_W-1:0]     shadow_cfg,
    input logic [CFG_W-1:0]     active_cfg,
    input logic [N_OPS-1:0]     src_valid,
    input logic [2*N_OPS-1:0]   dst_valid,
    input logic                 cfg_conflict
);

    // R8
    live_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_commit |=> $stable(active_cfg));

    // R9
    commit_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_commit |=> active_cfg == $past(shadow_cfg));

    // R10
    clash_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_commit |=> $stable(cfg_conflict));

    // R6
    op0_never_fed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid[1:0] == 2'b00);

    // R3
    one_stage_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_cfg[0] |=> dst_valid[2] == $past(src_valid[0]));

endmodule

bind fwd_op_net fwd_op_net_chk #(.N_OPS(N_OPS), .CFG_W(CFG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_commit   (cfg_commit),
    .shadow_cfg   (shadow_q),
    .active_cfg   (active_q),
    .src_valid    (src_valid),
    .dst_valid    (dst_valid),
    .cfg_conflict (cfg_conflict)
);

// File: tb/tb_fwd_op_net.sv
module tb_fwd_op_net;

    localparam int N     = 8;
    localparam int W     = 32;
    localparam int REACH = N / 2;
    localparam int CW    = N * REACH * 2;
    localparam int NIN   = N * 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_load = 1'b0;
    logic [CW-1:0]   cfg_word = '0;
    logic            cfg_commit = 1'b0;
    logic [N*W-1:0]  src_data = '0;
    logic [N-1:0]    src_valid = '0;
    logic [NIN*W-1:0] dst_data;
    logic [NIN-1:0]  dst_valid;
    logic            cfg_conflict;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [CW-1:0] shd_m = '0;
    logic [CW-1:0] act_m = '0;
    logic [CW-1:0] prv_m = '0;

    always #2 clk = ~clk;

    fwd_op_net #(.N_OPS(N), .DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
        .cfg_commit(cfg_commit), .src_data(src_data), .src_valid(src_valid),
        .dst_data(dst_data), .dst_valid(dst_valid), .cfg_conflict(cfg_conflict)
    );

    function automatic int lb(int s, int h, int p);
        return ((s * REACH) + (h - 1)) * 2 + p;
    endfunction

    // Advance one edge, tracking which live pattern registered the outputs.
    task automatic step();
        @(posedge clk);
        prv_m = act_m;
        @(negedge clk);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic drive_all(input logic [N-1:0] v, input logic [7:0] tag);
        for (int s = 0; s < N; s++)
            src_data[s*W +: W] = {tag, 8'(s), 16'h5A00 + 16'(s)};
        src_valid = v;
    endtask

    task automatic check_all(input string req);
        bit bad = 0;
        checks++;
        for (int k = 0; k < NIN; k++) begin
            int j = k / 2;
            int p = k % 2;
            logic [W-1:0] ed = '0;
            logic ev = 1'b0;
            bit found = 0;
            for (int s = 0; s < j; s++) begin
                if (!found && (j - s) <= REACH && prv_m[lb(s, j - s, p)]) begin
                    found = 1;
                    ed = src_data[s*W +: W];
                    ev = src_valid[s];
                end
            end
            if (!bad && (dst_data[k*W +: W] !== ed || dst_valid[k] !== ev)) begin
                bad = 1;
                failures++;
                $display("FAIL %s input %0d: actual data=%h valid=%b expected data=%h valid=%b",
                         req, k, dst_data[k*W +: W], dst_valid[k], ed, ev);
            end
        end
    endtask

    task automatic check_flag(input logic exp, input string req);
        checks++;
        if (cfg_conflict !== exp) begin
            failures++;
            $display("FAIL %s: actual conflict=%b expected=%b", req, cfg_conflict, exp);
        end
    endtask

    task automatic load_cfg(input logic [CW-1:0] w);
        cfg_load = 1'b1; cfg_word = w;
        @(posedge clk);
        prv_m = act_m;
        shd_m = w;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic commit_cfg();
        cfg_commit = 1'b1;
        @(posedge clk);
        prv_m = act_m;
        act_m = shd_m;
        @(negedge clk);
        cfg_commit = 1'b0;
    endtask

    task automatic t_reset();
        // R1: everything cleared after reset
        checks++;
        if (dst_valid !== '0 || dst_data !== '0) begin
            failures++;
            $display("FAIL R1 reset outputs: actual valid=%h expected=0", dst_valid);
        end
        check_flag(1'b0, "R1 reset clash flag");
        drive_all('1, 8'h11);
        step();
        check_all("R1 live pattern empty after reset (R5)");
    endtask

    task automatic t_basic();
        logic [CW-1:0] w = '0;
        w[lb(0, 1, 0)] = 1'b1;
        w[lb(2, 3, 1)] = 1'b1;
        load_cfg(w);
        commit_cfg();
        drive_all(8'hFF, 8'h22);
        step();
        check_all("R2 bit mapping");
        drive_all(8'hFF, 8'h23);
        step();
        check_all("R3 one-stage latency");
        drive_all(8'b1111_1010, 8'h24);
        step();
        check_all("R6 valid forwarded");
    endtask

    task automatic t_fanout();
        logic [CW-1:0] w = '0;
        w[lb(1, 1, 0)] = 1'b1;
        w[lb(1, 1, 1)] = 1'b1;
        w[lb(1, 2, 0)] = 1'b1;
        w[lb(1, 4, 1)] = 1'b1;
        load_cfg(w);
        commit_cfg();
        drive_all(8'hFF, 8'h33);
        step();
        check_all("R4 fan-out and R5 unlinked inputs");
    endtask

    task automatic t_out_of_range();
        logic [CW-1:0] w = '0;
        for (int h = 1; h <= REACH; h++) begin
            w[lb(7, h, 0)] = 1'b1;
            w[lb(7, h, 1)] = 1'b1;
        end
        w[lb(6, 2, 0)] = 1'b1;
        w[lb(5, 3, 1)] = 1'b1;
        load_cfg(w);
        commit_cfg();
        drive_all(8'hFF, 8'h44);
        step();
        checks++;
        if (dst_valid !== '0) begin
            failures++;
            $display("FAIL R2 out-of-range bits: actual valid=%h expected=0", dst_valid);
        end
        check_flag(1'b0, "R10 no clash for out-of-range bits");
    endtask

    task automatic t_staging();
        logic [CW-1:0] a = '0;
        logic [CW-1:0] b = '0;
        a[lb(3, 1, 0)] = 1'b1;
        b[lb(4, 2, 1)] = 1'b1;
        load_cfg(a);
        commit_cfg();
        drive_all(8'hFF, 8'h55);
        step();
        load_cfg(b);
        step();
        check_all("R8 load without commit keeps routing");
        commit_cfg();
        check_all("R9 commit edge still uses old pattern");
        step();
        check_all("R9 new pattern after commit");
        // R9: load and commit together, commit takes older staging value
        cfg_load = 1'b1; cfg_word = a; cfg_commit = 1'b1;
        @(posedge clk);
        prv_m = act_m;
        act_m = shd_m;
        shd_m = a;
        @(negedge clk);
        cfg_load = 1'b0; cfg_commit = 1'b0;
        step();
        check_all("R9 same-cycle load and commit");
    endtask

    task automatic t_clash();
        logic [CW-1:0] w = '0;
        w[lb(2, 3, 0)] = 1'b1;
        w[lb(3, 2, 0)] = 1'b1;
        w[lb(4, 1, 0)] = 1'b1;
        load_cfg(w);
        check_flag(1'b0, "R10 flag waits for commit");
        commit_cfg();
        check_flag(1'b1, "R10 clash raised at commit");
        drive_all(8'b0000_0100, 8'h66);
        step();
        check_all("R7 lowest-numbered source wins");
        load_cfg('0);
        check_flag(1'b1, "R10 clash held between commits");
        commit_cfg();
        check_flag(1'b0, "R10 clean commit clears clash");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_fanout();
        t_out_of_range();
        t_staging();
        t_clash();
        report();
    end

endmodule